// File: doc/BRIEF.md
# Dual-Channel Serial Result Shifter

This block is the output side of a two-channel sampling converter's serial port. A host pulls the active-low select low, which latches both 14-bit result words, and then toggles a serial clock. Each of the two data lines presents a 16-bit word: two zero bits, then its own channel's result with the most significant bit first. If the host keeps the select low and goes on clocking, the line shifts two more zeros and then the other channel's result. This lets a host with a single data input read both channels from one line in a 32-clock frame.

Each line has its own enable output, and a pad driver puts the line into high impedance whenever that enable is low. The enables drop when the select returns high. They also drop on their own after the 32nd falling serial clock edge, even if the select is still low. A select release that falls after the tenth falling edge and before the sixteenth cuts a conversion short. The block reports this with a one-cycle abort flag. The select and serial clock are sampled by the block's system clock, so the serial clock must run at well under half the system clock rate.

Top module: `dual_result_shifter`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, both enables, both data outputs and the abort flag are low.
- R2: Both result inputs are captured in the cycle in which a falling select is seen. Changes to the result inputs later in the same frame do not affect either data line.
- R3: One cycle after a falling select is seen, both enables are high and each line presents frame bit 0. Each detected falling serial clock edge advances the line by one bit. Frame bits 0 and 1 are zero and bits 2 to 15 carry the line's own result, bit 13 first.
- R4: If the select is still low, frame bits 16 and 17 (after the 16th and 17th falling edges) are zero.
- R5: Frame bits 18 to 31 carry the other channel's result, bit 13 first. Line A carries B and line B carries A.
- R6: The falling edge that would advance past bit 31 (the 32nd) drops both enables and drives both data outputs low. They stay low for any further serial clocks until the select rises and falls again.
- R7: One cycle after the select is seen high, both enables and both data outputs are low. Serial clock activity while the select is high has no effect.
- R8: When the select is seen rising after at least 10 and fewer than 16 falling edges of the current frame, the abort flag is high for exactly one cycle. A rise at any other count leaves it low.
- R9: Rising serial clock edges and idle cycles do not change the data outputs within a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples select and serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select; its falling edge starts a frame |
| sclk | input | 1 | Serial clock; its falling edges advance the frame |
| res_a | input | 14 | Channel A result word |
| res_b | input | 14 | Channel B result word |
| sdo_a | output | 1 | Data line A (low when not enabled) |
| sdo_b | output | 1 | Data line B (low when not enabled) |
| oe_a | output | 1 | Drive enable for line A; low means high impedance |
| oe_b | output | 1 | Drive enable for line B; low means high impedance |
| conv_abort | output | 1 | One-cycle flag for a release in the abort window |

## Verification
The assertions check four rules on every cycle. The reset state is clean. A select seen high forces both lines off. A line never changes without a detected falling serial clock edge, and it starts every frame with a zero. The abort flag is a single-cycle pulse that follows a select release with the lines already off. The bench's behavioural model is a bit queue that is refilled at each select fall and popped on each falling edge. Only this model can show the bit order of both words and the swap of channels on each line. It also shows the capture of results against later input changes, the self-release after the 32nd edge, and the exact edge counts that raise or do not raise the abort flag.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    // Frame progress of the shared controller.
    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,  // lines released, waiting for select to fall
        FS_SHIFT = 2'd1,  // lines driven, bits advancing
        FS_SPENT = 2'd2   // frame exhausted, select still low
    } frame_state_e;

    // Edge events seen in one system clock cycle.
    typedef struct packed {
        logic cs_fall;    // select was high, now low
        logic cs_high;    // select currently high
        logic sclk_fall;  // serial clock was high, now low
    } edge_ev_t;

    // Per-cycle commands to the lane shifters.
    typedef struct packed {
        logic load;  // capture results into the frame register
        logic adv;   // advance one bit
        logic en;    // drive the lines
    } lane_ctl_t;

endpackage

// File: rtl/dcs_edge_sense.sv
module dcs_edge_sense
    import dcs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_n,
    input  logic     sclk,
    output edge_ev_t ev
);

    logic cs_q;
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            cs_q   <= cs_n;
            sclk_q <= sclk;
        end
    end

    always_comb begin
        ev.cs_fall   = cs_q & ~cs_n;
        ev.cs_high   = cs_n;
        ev.sclk_fall = sclk_q & ~sclk;
    end

endmodule

// File: rtl/dcs_frame_ctrl.sv
module dcs_frame_ctrl
    import dcs_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int FRAME_EDGES = 32,
    parameter int ABORT_MIN   = 10
) (
    input  logic      clk,
    input  logic      rst,
    input  edge_ev_t  ev,
    output lane_ctl_t ctl,
    output logic      conv_abort
);

    localparam int CNT_W = $clog2(FRAME_EDGES + 1);

    frame_state_e st;
    logic [CNT_W-1:0] edge_cnt;
    logic in_abort_win;

    assign in_abort_win = (edge_cnt >= CNT_W'(ABORT_MIN)) &&
                          (edge_cnt <  CNT_W'(WORD_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= FS_IDLE;
            edge_cnt   <= '0;
            conv_abort <= 1'b0;
        end else begin
            conv_abort <= 1'b0;
            if (ev.cs_high) begin
                if (st == FS_SHIFT && in_abort_win) begin
                    conv_abort <= 1'b1;
                end
                st <= FS_IDLE;
            end else if (ev.cs_fall) begin
                st       <= FS_SHIFT;
                edge_cnt <= '0;
            end else if (st == FS_SHIFT && ev.sclk_fall) begin
                edge_cnt <= edge_cnt + 1'b1;
                if (edge_cnt == CNT_W'(FRAME_EDGES - 1)) begin
                    st <= FS_SPENT;
                end
            end
        end
    end

    always_comb begin
        ctl.load = ev.cs_fall;
        ctl.adv  = (st == FS_SHIFT) & ev.sclk_fall & ~ev.cs_high & ~ev.cs_fall;
        ctl.en   = (st == FS_SHIFT);
    end

endmodule

// File: rtl/dcs_lane.sv
module dcs_lane
    import dcs_pkg::*;
#(
    parameter int RES_W  = 14,
    parameter int LEAD_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  lane_ctl_t        ctl,
    input  logic [RES_W-1:0] own_res,
    input  logic [RES_W-1:0] other_res,
    output logic             sdo
);

    localparam int WORD_W  = RES_W + LEAD_W;
    localparam int FRAME_W = 2 * WORD_W;

    logic [FRAME_W-1:0] frame_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
        end else if (ctl.load) begin
            frame_q <= {{LEAD_W{1'b0}}, own_res, {LEAD_W{1'b0}}, other_res};
        end else if (ctl.adv) begin
            frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
        end
    end

    assign sdo = ctl.en & frame_q[FRAME_W-1];

endmodule

// File: rtl/dual_result_shifter.sv
module dual_result_shifter
    import dcs_pkg::*;
#(
    parameter int RES_W     = 14,
    parameter int LEAD_W    = 2,
    parameter int ABORT_MIN = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic [RES_W-1:0] res_a,
    input  logic [RES_W-1:0] res_b,
    output logic             sdo_a,
    output logic             sdo_b,
    output logic             oe_a,
    output logic             oe_b,
    output logic             conv_abort
);

    localparam int WORD_W      = RES_W + LEAD_W;
    localparam int FRAME_EDGES = 2 * WORD_W;
    localparam int N_LANES     = 2;

    edge_ev_t  ev;
    lane_ctl_t ctl;
    logic [RES_W-1:0] res_arr [N_LANES];
    logic [N_LANES-1:0] sdo_vec;

    assign res_arr[0] = res_a;
    assign res_arr[1] = res_b;

    dcs_edge_sense i_edge (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .sclk (sclk),
        .ev   (ev)
    );

    dcs_frame_ctrl #(
        .WORD_W      (WORD_W),
        .FRAME_EDGES (FRAME_EDGES),
        .ABORT_MIN   (ABORT_MIN)
    ) i_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .ctl        (ctl),
        .conv_abort (conv_abort)
    );

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        dcs_lane #(
            .RES_W  (RES_W),
            .LEAD_W (LEAD_W)
        ) i_lane (
            .clk       (clk),
            .rst       (rst),
            .ctl       (ctl),
            .own_res   (res_arr[g]),
            .other_res (res_arr[N_LANES-1-g]),
            .sdo       (sdo_vec[g])
        );
    end

    assign sdo_a = sdo_vec[0];
    assign sdo_b = sdo_vec[1];
    assign oe_a  = ctl.en;
    assign oe_b  = ctl.en;

endmodule

// File: rtl/dcs_checker.sv
module dcs_checker (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic sclk,
    input logic sdo_a,
    input logic sdo_b,
    input logic oe_a,
    input logic oe_b,
    input logic conv_abort
);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!oe_a && !oe_b && !sdo_a && !sdo_b && !conv_abort));

    assert_select_high_off_R7: assert property (@(posedge clk) disable iff (rst)
        $past(cs_n) |-> (!oe_a && !oe_b && !sdo_a && !sdo_b));

    assert_first_bit_zero_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_a) |-> (!sdo_a && !sdo_b));

    assert_hold_a_R9: assert property (@(posedge clk) disable iff (rst)
        (oe_a && $past(oe_a) && !($past(sclk, 2) && !$past(sclk))) |-> $stable(sdo_a));

    assert_hold_b_R9: assert property (@(posedge clk) disable iff (rst)
        (oe_b && $past(oe_b) && !($past(sclk, 2) && !$past(sclk))) |-> $stable(sdo_b));

    assert_abort_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        conv_abort |=> !conv_abort);

    assert_abort_after_rise_R8: assert property (@(posedge clk) disable iff (rst)
        conv_abort |-> ($past(cs_n) && !oe_a && !oe_b));

endmodule

bind dual_result_shifter dcs_checker i_dcs_checker (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .sclk       (sclk),
    .sdo_a      (sdo_a),
    .sdo_b      (sdo_b),
    .oe_a       (oe_a),
    .oe_b       (oe_b),
    .conv_abort (conv_abort)
);

// File: tb/test_dual_result_shifter.sv
`timescale 1ns/1ps
module test_dual_result_shifter;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic [13:0] res_a = '0;
    logic [13:0] res_b = '0;
    logic sdo_a, sdo_b, oe_a, oe_b, conv_abort;

    always #5 clk = ~clk;

    dual_result_shifter i_dual_result_shifter (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .res_a      (res_a),
        .res_b      (res_b),
        .sdo_a      (sdo_a),
        .sdo_b      (sdo_b),
        .oe_a       (oe_a),
        .oe_b       (oe_b),
        .conv_abort (conv_abort)
    );

    int total = 0;
    int fails = 0;
    int abort_seen = 0;
    string phase = "R1 reset";

    // Behavioural reference: a bit queue per line.
    bit qa[$];
    bit qb[$];
    bit m_act = 0;
    bit m_abort = 0;
    bit m_prev_cs = 1;
    bit m_prev_sclk = 0;
    int m_edges = 0;

    function automatic void fill(ref bit q[$], input logic [13:0] own, input logic [13:0] oth);
        q = {};
        q.push_back(1'b0);
        q.push_back(1'b0);
        for (int i = 13; i >= 0; i--) q.push_back(own[i]);
        q.push_back(1'b0);
        q.push_back(1'b0);
        for (int i = 13; i >= 0; i--) q.push_back(oth[i]);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_act = 0; m_abort = 0; m_prev_cs = 1; m_prev_sclk = 0; m_edges = 0;
            qa = {}; qb = {};
        end else begin
            m_abort = 0;
            if (cs_n) begin
                if (m_act && m_edges >= 10 && m_edges < 16) m_abort = 1;
                m_act = 0;
            end else if (m_prev_cs) begin
                fill(qa, res_a, res_b);
                fill(qb, res_b, res_a);
                m_act = 1;
                m_edges = 0;
            end else if (m_act && m_prev_sclk && !sclk) begin
                void'(qa.pop_front());
                void'(qb.pop_front());
                m_edges++;
                if (m_edges == 32) m_act = 0;
            end
            m_prev_cs = cs_n;
            m_prev_sclk = sclk;
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk({phase, " oe_a"}, oe_a, m_act);
            chk({phase, " oe_b"}, oe_b, m_act);
            chk({phase, " sdo_a"}, sdo_a, m_act ? qa[0] : 1'b0);
            chk({phase, " sdo_b"}, sdo_b, m_act ? qb[0] : 1'b0);
            chk({phase, " abort"}, conv_abort, m_abort);
            if (conv_abort) abort_seen++;
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic pulse();
        sclk = 1'b1; step(2);
        sclk = 1'b0; step(2);
    endtask

    task automatic frame(logic [13:0] a, logic [13:0] b, int edges);
        res_a = a; res_b = b;
        cs_n = 1'b0; step(2);
        repeat (edges) pulse();
        cs_n = 1'b1; step(3);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        step(4);
        @(negedge clk);
        chk("R1 oe_a in reset", oe_a, 1'b0);
        chk("R1 sdo_a in reset", sdo_a, 1'b0);
        chk("R1 abort in reset", conv_abort, 1'b0);
        step(1);
        rst = 1'b0;
        step(3);

        phase = "R3 single word";
        frame(14'h2AB5, 14'h1C3E, 16);
        phase = "R3 all ones";
        frame(14'h3FFF, 14'h0000, 16);

        phase = "R4 trailing zeros";
        frame(14'h3FFF, 14'h3FFF, 18);

        phase = "R5 dual read";
        frame(14'h1234, 14'h2ACF, 32);

        phase = "R6 self release";
        res_a = 14'h3FFF; res_b = 14'h3FFF;
        cs_n = 1'b0; step(2);
        repeat (32) pulse();
        repeat (4) pulse();
        @(negedge clk);
        chk("R6 oe_a after 32 edges", oe_a, 1'b0);
        chk("R6 sdo_b after 32 edges", sdo_b, 1'b0);
        step(1);
        cs_n = 1'b1; step(3);

        phase = "R2 capture";
        res_a = 14'h0F0F; res_b = 14'h30C3;
        cs_n = 1'b0; step(2);
        repeat (3) pulse();
        res_a = 14'h3FFF; res_b = 14'h0000;
        repeat (29) pulse();
        cs_n = 1'b1; step(3);

        phase = "R7 idle clocks";
        repeat (6) pulse();
        @(negedge clk);
        chk("R7 oe_a idle", oe_a, 1'b0);
        chk("R7 sdo_a idle", sdo_a, 1'b0);
        step(1);

        phase = "R8 abort window";
        abort_seen = 0;
        frame(14'h2222, 14'h1111, 12);
        chk("R8 abort at 12 edges", logic'(abort_seen == 1), 1'b1);
        abort_seen = 0;
        frame(14'h2222, 14'h1111, 10);
        chk("R8 abort at 10 edges", logic'(abort_seen == 1), 1'b1);
        abort_seen = 0;
        frame(14'h2222, 14'h1111, 9);
        chk("R8 no abort at 9 edges", logic'(abort_seen == 0), 1'b1);
        abort_seen = 0;
        frame(14'h2222, 14'h1111, 16);
        chk("R8 no abort at 16 edges", logic'(abort_seen == 0), 1'b1);
        abort_seen = 0;
        frame(14'h2222, 14'h1111, 15);
        chk("R8 abort at 15 edges", logic'(abort_seen == 1), 1'b1);

        phase = "R9 slow clock";
        res_a = 14'h2D4B; res_b = 14'h12B4;
        cs_n = 1'b0; step(3);
        for (int k = 0; k < 20; k++) begin
            sclk = 1'b1; step(5);
            sclk = 1'b0; step(3);
        end
        cs_n = 1'b1; step(3);

        finish_run();
    end

endmodule